// File: doc/BRIEF.md
# Serial Frame Receiver with Address Filtering

This block turns an asynchronous serial line into received words of 8 or 9 data bits. The line is resynchronised, a start bit is confirmed at its midpoint, and each data bit and the stop bit are then sampled at mid-bit, least significant bit first. The bit rate comes from an 8-bit divisor that sets the sample tick period. A speed select sets 16 or 64 ticks per bit.

An optional address filter supports multi-drop buses. It looks at the top bit of each word: bit 7 for short frames and bit 8 for long frames. Words with that bit set are passed on as addresses. Words with it clear are dropped without a trace. Received words leave through a valid/ready port. The line cannot be stalled, so a word that finishes while the previous one is still held is lost and raises a sticky overrun flag. Software can enable the receiver or abort it at any time.

Two small pieces sit beside the receiver. One merges the receive flags and two transmitter status flags into one interrupt request, each source gated by its own enable. The other gives a one-cycle wake pulse on a falling line edge while the system is powered down.

Top module: `serial_addr_rx`

## Requirements
- R1: Let T = baud_div_i + 1 clocks and OS = 16 when fast_baud_i = 1 or 64 otherwise. The line passes two synchronizer flops. The first clock edge that sees the synchronized line low while idle and armed starts a frame; call it edge S. The start bit is re-checked at edge S + T*OS/2, and if the line is high there the frame is abandoned. Data bit i is sampled at edge S + T*(OS/2 + (i+1)*OS), LSB first. There are 9 bits when long_frame_i = 1 and 8 otherwise. rx_data_o is right-aligned, with bit 8 equal to 0 for 8-bit frames.
- R2: The stop bit is sampled at edge S + T*(OS/2 + (N+1)*OS), where N is the bit count, and at that edge an accepted word sets rx_valid_o. rx_valid_o and rx_data_o then hold until an edge sees rx_valid_o and rx_ready_i both high. If a new word completes at that same edge, it is accepted.
- R3: With addr_filter_i = 1, the address flag is bit 7 of the word for 8-bit frames and bit 8 for 9-bit frames. A word whose flag is 1 is delivered as in R2.
- R4: With addr_filter_i = 1, a word whose flag is 0 is discarded. It changes neither rx_valid_o, rx_data_o nor overrun_o, and it raises no interrupt.
- R5: If an accepted word completes while rx_valid_o is high and rx_ready_i is low, overrun_o is set. The new word is dropped and the held word stays. overrun_o stays set while the receiver is active.
- R6: frame_err_o takes the inverse of the sampled stop bit of every delivered word. The word is still delivered when the stop bit is 0.
- R7: When rx_en_i or uart_en_i is 0, the next edge returns the receiver to idle. That edge abandons any frame in progress and clears rx_valid_o, overrun_o, frame_err_o and rx_data_o. No frame starts while the receiver is inactive.
- R8: rx_own_o is 1 exactly when rx_en_i and uart_en_i are both 1; otherwise the line is left to other use.
- R9: irq_o is a register. At each edge it takes (rie_i & (overrun_o | rx_valid_o)) | (tx_empty_ie_i & tx_empty_i) | (tx_idle_ie_i & tx_idle_i). A flag whose enable is 0 has no effect.
- R10: If the line input falls and wake_en_i and pwr_down_i are both 1 at the third clock edge after the fall, wake_o is high for exactly the one cycle that follows that edge. With either of them at 0, no pulse is produced.
- R11: After a frame ends, and after enabling, no new start is taken until the synchronized line has been seen high. A stop bit followed by a long low level (a break) therefore yields only one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial line |
| uart_en_i | input | 1 | Global serial port enable |
| rx_en_i | input | 1 | Receiver enable; 0 aborts and clears |
| addr_filter_i | input | 1 | Address filter mode |
| long_frame_i | input | 1 | 1: 9 data bits, 0: 8 data bits |
| fast_baud_i | input | 1 | 1: 16 ticks per bit, 0: 64 ticks per bit |
| baud_div_i | input | 8 | Tick period minus one, in clocks |
| rx_ready_i | input | 1 | Consumer accepts the held word |
| rie_i | input | 1 | Receive interrupt enable |
| tx_empty_ie_i | input | 1 | Transmit-empty interrupt enable |
| tx_idle_ie_i | input | 1 | Transmit-idle interrupt enable |
| tx_empty_i | input | 1 | Transmitter empty flag |
| tx_idle_i | input | 1 | Transmitter idle flag |
| wake_en_i | input | 1 | Line wake-up enable |
| pwr_down_i | input | 1 | System is powered down |
| rx_data_o | output | 9 | Received word |
| rx_valid_o | output | 1 | Word held (receive flag) |
| overrun_o | output | 1 | Sticky overrun flag |
| frame_err_o | output | 1 | Stop bit of last word was 0 |
| irq_o | output | 1 | Merged interrupt request |
| wake_o | output | 1 | One-cycle wake pulse |
| rx_own_o | output | 1 | Receiver owns the line pin |

## Verification
The bench aims at the address filter in both frame lengths. A filter that reads the wrong flag bit would drop addresses or let data words raise the receive flag and the interrupt. It fills the holding register twice without a read. A wrong overrun path would either overwrite the held word or never set the sticky flag. It also aborts a frame halfway and sends a stop bit followed by a long break. A receiver that kept partial state would later emit a stray word, and one that re-armed on the low level would produce a phantom all-zero frame. Slow and fast tick modes and every interrupt enable are swept against a model that predicts each output cycle by cycle, so a one-tick sampling offset or a misrouted enable shows up as a mismatch at the exact edge.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/srx_sync.sv
// Line resynchronizer with falling-edge detect.
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s_o,
  output logic fell_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q[g] <= 1'b1;
        else        chain_q[g] <= line_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q[g] <= 1'b1;
        else        chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];

  assign line_s_o = chain_q[STAGES-1];
  assign fell_o   = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/srx_tick.sv
// Sample tick divider, held in phase while cleared.
module srx_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (cnt_q == div_i)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;

  assign tick_o = !clr_i && (cnt_q == div_i);
endmodule

// File: rtl/srx_frame.sv
// Frame sequencer, address filter and holding register.
module srx_frame
  import srx_pkg::*;
#(
  parameter int WORD_W  = 9,
  parameter int OS_FAST = 16,
  parameter int OS_SLOW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              line_s_i,
  input  logic              tick_i,
  input  logic              long_i,
  input  logic              fast_i,
  input  logic              filt_i,
  input  logic              ready_i,
  output logic              tick_clr_o,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o,
  output logic              ovr_o,
  output logic              ferr_o
);
  localparam int SW = $clog2(OS_SLOW);
  localparam int BW = $clog2(WORD_W);
  localparam logic [SW-1:0] FAST_LAST = SW'(OS_FAST - 1);
  localparam logic [SW-1:0] SLOW_LAST = SW'(OS_SLOW - 1);
  localparam logic [SW-1:0] FAST_HALF = SW'(OS_FAST / 2 - 1);
  localparam logic [SW-1:0] SLOW_HALF = SW'(OS_SLOW / 2 - 1);
  localparam logic [BW-1:0] LONG_LAST  = BW'(WORD_W - 1);
  localparam logic [BW-1:0] SHORT_LAST = BW'(WORD_W - 2);

  rx_state_e         st_q;
  logic [SW-1:0]     scnt_q;
  logic [BW-1:0]     bcnt_q;
  logic [WORD_W-1:0] sh_q;
  logic              armed_q;

  logic [SW-1:0]     bit_last, half_last;
  logic [BW-1:0]     bits_last;
  logic [WORD_W-1:0] word;
  logic              flag, keep;

  assign bit_last  = fast_i ? FAST_LAST : SLOW_LAST;
  assign half_last = fast_i ? FAST_HALF : SLOW_HALF;
  assign bits_last = long_i ? LONG_LAST : SHORT_LAST;

  for (genvar g = 0; g < WORD_W; g++) begin : g_word
    if (g == WORD_W - 1) begin : g_top
      assign word[g] = long_i & sh_q[g];
    end else begin : g_low
      assign word[g] = sh_q[g];
    end
  end

  assign flag       = long_i ? sh_q[WORD_W-1] : sh_q[WORD_W-2];
  assign keep       = !filt_i || flag;
  assign tick_clr_o = (st_q == RX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      scnt_q  <= '0;
      bcnt_q  <= '0;
      sh_q    <= '0;
      armed_q <= 1'b0;
      data_o  <= '0;
      valid_o <= 1'b0;
      ovr_o   <= 1'b0;
      ferr_o  <= 1'b0;
    end else if (!active_i) begin
      st_q    <= RX_IDLE;
      scnt_q  <= '0;
      bcnt_q  <= '0;
      armed_q <= 1'b0;
      data_o  <= '0;
      valid_o <= 1'b0;
      ovr_o   <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      if (valid_o && ready_i) valid_o <= 1'b0;
      unique case (st_q)
        RX_IDLE: begin
          if (line_s_i) begin
            armed_q <= 1'b1;
          end else if (armed_q) begin
            st_q    <= RX_START;
            scnt_q  <= '0;
            armed_q <= 1'b0;
          end
        end
        RX_START: if (tick_i) begin
          if (scnt_q == half_last) begin
            scnt_q <= '0;
            bcnt_q <= '0;
            st_q   <= line_s_i ? RX_IDLE : RX_BITS;
          end else begin
            scnt_q <= scnt_q + 1'b1;
          end
        end
        RX_BITS: if (tick_i) begin
          if (scnt_q == bit_last) begin
            scnt_q       <= '0;
            sh_q[bcnt_q] <= line_s_i;
            if (bcnt_q == bits_last) st_q   <= RX_STOP;
            else                     bcnt_q <= bcnt_q + 1'b1;
          end else begin
            scnt_q <= scnt_q + 1'b1;
          end
        end
        RX_STOP: if (tick_i) begin
          if (scnt_q == bit_last) begin
            scnt_q <= '0;
            st_q   <= RX_IDLE;
            if (keep) begin
              if (valid_o && !ready_i) begin
                ovr_o <= 1'b1;
              end else begin
                data_o  <= word;
                valid_o <= 1'b1;
                ferr_o  <= !line_s_i;
              end
            end
          end else begin
            scnt_q <= scnt_q + 1'b1;
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srx_merge.sv
// Interrupt merge and power-down wake pulse, both registered.
module srx_merge (
  input  logic clk,
  input  logic rst_n,
  input  logic rie_i,
  input  logic teie_i,
  input  logic tiie_i,
  input  logic valid_i,
  input  logic ovr_i,
  input  logic tx_empty_i,
  input  logic tx_idle_i,
  input  logic wake_en_i,
  input  logic pwr_down_i,
  input  logic fell_i,
  output logic irq_o,
  output logic wake_o
);
  logic rx_src, tx_src;

  assign rx_src = rie_i & (ovr_i | valid_i);
  assign tx_src = (teie_i & tx_empty_i) | (tiie_i & tx_idle_i);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      irq_o  <= rx_src | tx_src;
      wake_o <= wake_en_i & pwr_down_i & fell_i;
    end
endmodule

// File: rtl/serial_addr_rx.sv
module serial_addr_rx #(
  parameter int DIV_W   = 8,
  parameter int WORD_W  = 9,
  parameter int OS_FAST = 16,
  parameter int OS_SLOW = 64,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              uart_en_i,
  input  logic              rx_en_i,
  input  logic              addr_filter_i,
  input  logic              long_frame_i,
  input  logic              fast_baud_i,
  input  logic [DIV_W-1:0]  baud_div_i,
  input  logic              rx_ready_i,
  input  logic              rie_i,
  input  logic              tx_empty_ie_i,
  input  logic              tx_idle_ie_i,
  input  logic              tx_empty_i,
  input  logic              tx_idle_i,
  input  logic              wake_en_i,
  input  logic              pwr_down_i,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              overrun_o,
  output logic              frame_err_o,
  output logic              irq_o,
  output logic              wake_o,
  output logic              rx_own_o
);
  logic active, line_s, fell, tick, tick_clr;

  assign active   = rx_en_i & uart_en_i;
  assign rx_own_o = active;

  srx_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(rx_i),
    .line_s_o(line_s), .fell_o(fell)
  );

  srx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr_i(tick_clr),
    .div_i(baud_div_i), .tick_o(tick)
  );

  srx_frame #(.WORD_W(WORD_W), .OS_FAST(OS_FAST), .OS_SLOW(OS_SLOW)) u_frame (
    .clk(clk), .rst_n(rst_n), .active_i(active), .line_s_i(line_s),
    .tick_i(tick), .long_i(long_frame_i), .fast_i(fast_baud_i),
    .filt_i(addr_filter_i), .ready_i(rx_ready_i), .tick_clr_o(tick_clr),
    .data_o(rx_data_o), .valid_o(rx_valid_o), .ovr_o(overrun_o),
    .ferr_o(frame_err_o)
  );

  srx_merge u_merge (
    .clk(clk), .rst_n(rst_n), .rie_i(rie_i), .teie_i(tx_empty_ie_i),
    .tiie_i(tx_idle_ie_i), .valid_i(rx_valid_o), .ovr_i(overrun_o),
    .tx_empty_i(tx_empty_i), .tx_idle_i(tx_idle_i), .wake_en_i(wake_en_i),
    .pwr_down_i(pwr_down_i), .fell_i(fell), .irq_o(irq_o), .wake_o(wake_o)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int WORD_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              uart_en_i,
  input logic              rx_en_i,
  input logic              rx_ready_i,
  input logic              rie_i,
  input logic              tx_empty_ie_i,
  input logic              tx_idle_ie_i,
  input logic              tx_empty_i,
  input logic              tx_idle_i,
  input logic              wake_en_i,
  input logic              pwr_down_i,
  input logic [WORD_W-1:0] rx_data_o,
  input logic              rx_valid_o,
  input logic              overrun_o,
  input logic              frame_err_o,
  input logic              irq_o,
  input logic              wake_o
);
  logic act;
  assign act = rx_en_i & uart_en_i;

  // R2: a held word is stable until taken
  p_hold_until_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i && act) |=> (rx_valid_o && $stable(rx_data_o)));

  // R5: overrun is sticky while active
  p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o && act) |=> overrun_o);

  // R7: inactive receiver holds nothing
  p_abort_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> (!rx_valid_o && !overrun_o && !frame_err_o));

  // R9: interrupt follows the gated flags one edge later
  p_irq_merge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq_o == $past((rie_i && (overrun_o || rx_valid_o)) ||
                                     (tx_empty_ie_i && tx_empty_i) ||
                                     (tx_idle_ie_i && tx_idle_i))));

  // R10: wake needs both enables and lasts one cycle
  p_wake_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(wake_en_i && pwr_down_i));
  p_wake_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);
endmodule

bind serial_addr_rx srx_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .uart_en_i(uart_en_i), .rx_en_i(rx_en_i),
  .rx_ready_i(rx_ready_i), .rie_i(rie_i), .tx_empty_ie_i(tx_empty_ie_i),
  .tx_idle_ie_i(tx_idle_ie_i), .tx_empty_i(tx_empty_i), .tx_idle_i(tx_idle_i),
  .wake_en_i(wake_en_i), .pwr_down_i(pwr_down_i), .rx_data_o(rx_data_o),
  .rx_valid_o(rx_valid_o), .overrun_o(overrun_o), .frame_err_o(frame_err_o),
  .irq_o(irq_o), .wake_o(wake_o)
);

// File: tb/serial_addr_rx_tb.sv
`timescale 1ns/1ps
module serial_addr_rx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1, uart_en = 1'b1, rx_en = 1'b1, filt = 1'b0, long_f = 1'b0;
  logic fast = 1'b1, rdy = 1'b0, rie = 1'b0, teie = 1'b0, tiie = 1'b0;
  logic tx_empty = 1'b0, tx_idle = 1'b0, wake_en = 1'b0, pdn = 1'b0;
  logic [7:0] div = 8'd1;
  logic [8:0] d_o;
  logic v_o, ovr_o, ferr_o, irq_o, wake_o, own_o;

  always #5 clk = ~clk;

  serial_addr_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .uart_en_i(uart_en), .rx_en_i(rx_en),
    .addr_filter_i(filt), .long_frame_i(long_f), .fast_baud_i(fast),
    .baud_div_i(div), .rx_ready_i(rdy), .rie_i(rie), .tx_empty_ie_i(teie),
    .tx_idle_ie_i(tiie), .tx_empty_i(tx_empty), .tx_idle_i(tx_idle),
    .wake_en_i(wake_en), .pwr_down_i(pdn), .rx_data_o(d_o), .rx_valid_o(v_o),
    .overrun_o(ovr_o), .frame_err_o(ferr_o), .irq_o(irq_o), .wake_o(wake_o),
    .rx_own_o(own_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  int fall_cyc = -100, pend_at = -1;
  logic [8:0] pend_word = '0;
  bit pend_stop = 1'b1;
  bit m_valid = 0, m_ovr = 0, m_ferr = 0, m_irq = 0, m_wake = 0, old_v, flag;
  logic [8:0] m_data = '0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge.
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_valid = 0; m_ovr = 0; m_ferr = 0; m_irq = 0; m_wake = 0;
      m_data = '0; pend_at = -1;
    end else begin
      m_irq  = (rie && (m_ovr || m_valid)) || (teie && tx_empty) || (tiie && tx_idle);
      m_wake = (cyc == fall_cyc + 3) && wake_en && pdn;
      if (!(rx_en && uart_en)) begin
        m_valid = 0; m_ovr = 0; m_ferr = 0; m_data = '0; pend_at = -1;
      end else begin
        old_v = m_valid;
        if (m_valid && rdy) m_valid = 0;
        if (cyc == pend_at) begin
          flag = long_f ? pend_word[8] : pend_word[7];
          if (!filt || flag) begin
            if (old_v && !rdy) m_ovr = 1;
            else begin
              m_valid = 1;
              m_data  = long_f ? pend_word : {1'b0, pend_word[7:0]};
              m_ferr  = !pend_stop;
            end
          end
        end
      end
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) if (rst_n && !finished) begin
    chk(v_o == m_valid, "R2 valid", int'(v_o), int'(m_valid));
    if (m_valid) chk(d_o == m_data, "R1 data", int'(d_o), int'(m_data));
    chk(ovr_o == m_ovr, "R5 overrun", int'(ovr_o), int'(m_ovr));
    chk(ferr_o == m_ferr, "R6 frame error", int'(ferr_o), int'(m_ferr));
    chk(irq_o == m_irq, "R9 irq", int'(irq_o), int'(m_irq));
    chk(wake_o == m_wake, "R10 wake", int'(wake_o), int'(m_wake));
    chk(own_o == (rx_en && uart_en), "R8 own", int'(own_o), int'(rx_en && uart_en));
  end

  function automatic int bit_cyc();
    return (int'(div) + 1) * (fast ? 16 : 64);
  endfunction

  // Called right after a falling clock edge.
  task automatic send(input logic [8:0] w, input bit stopv, input int hold);
    int bt = bit_cyc();
    int os = fast ? 16 : 64;
    int nb = long_f ? 9 : 8;
    rx = 1'b0;
    fall_cyc  = cyc;
    pend_word = w;
    pend_stop = stopv;
    pend_at   = cyc + 3 + (int'(div) + 1) * (os / 2 + (nb + 1) * os);
    repeat (bt) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rx = w[i];
      repeat (bt) @(negedge clk);
    end
    rx = stopv;
    repeat (bt * (1 + hold)) @(negedge clk);
    rx = 1'b1;
    repeat (bt) @(negedge clk);
  endtask

  task automatic take();
    rdy = 1'b1;
    @(negedge clk);
    rdy = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(v_o == 0 && ovr_o == 0 && irq_o == 0 && wake_o == 0, "R2 reset state",
        {v_o, ovr_o, irq_o, wake_o}, 0);
    repeat (4) @(negedge clk);

    // R1: 8-bit frame, fast ticks, divisor 1
    send(9'h0A5, 1'b1, 0);
    chk(v_o && d_o == 9'h0A5, "R1 short frame", int'(d_o), 'h0A5);
    take();
    chk(!v_o, "R2 read clears", int'(v_o), 0);

    // R1: 9-bit frame, slow ticks, divisor 0, with interrupt enabled
    long_f = 1; fast = 0; div = 8'd0; rie = 1;
    send(9'h13C, 1'b1, 0);
    chk(v_o && d_o == 9'h13C, "R1 long frame slow", int'(d_o), 'h13C);
    chk(irq_o, "R9 receive irq", int'(irq_o), 1);
    take();
    long_f = 0; fast = 1; div = 8'd1;

    // R5: overrun keeps the first word
    send(9'h011, 1'b1, 0);
    send(9'h022, 1'b1, 0);
    chk(ovr_o && d_o == 9'h011, "R5 overrun keeps held", int'(d_o), 'h011);
    take();
    chk(ovr_o && !v_o, "R5 sticky after read", int'(ovr_o), 1);
    rx_en = 0; @(negedge clk);
    chk(!ovr_o, "R7 abort clears overrun", int'(ovr_o), 0);
    rx_en = 1; repeat (4) @(negedge clk);

    // R3/R4: address filter, 8-bit frames (flag is bit 7)
    filt = 1;
    send(9'h035, 1'b1, 0);
    chk(!v_o && !irq_o, "R4 short data word dropped", int'(v_o), 0);
    send(9'h0B5, 1'b1, 0);
    chk(v_o && d_o == 9'h0B5, "R3 short address accepted", int'(d_o), 'h0B5);
    take();

    // R3/R4: address filter, 9-bit frames (flag is bit 8)
    long_f = 1;
    send(9'h0FF, 1'b1, 0);
    chk(!v_o, "R4 long data word dropped", int'(v_o), 0);
    send(9'h101, 1'b1, 0);
    chk(v_o && d_o == 9'h101, "R3 long address accepted", int'(d_o), 'h101);
    take();
    long_f = 0; filt = 0; rie = 0;

    // R6: bad stop bit still delivers
    send(9'h05A, 1'b0, 0);
    chk(v_o && ferr_o && d_o == 9'h05A, "R6 framing error flagged", int'(ferr_o), 1);
    take();
    send(9'h05A, 1'b1, 0);
    chk(v_o && !ferr_o, "R6 good stop clears", int'(ferr_o), 0);
    take();

    // R11: break after stop bit yields a single word
    send(9'h000, 1'b0, 3);
    take();
    repeat (bit_cyc() * 10) @(negedge clk);
    chk(!v_o, "R11 no phantom frame after break", int'(v_o), 0);

    // R7: abort in the middle of a frame
    fork
      send(9'h077, 1'b1, 0);
      begin
        repeat (bit_cyc() * 3) @(negedge clk);
        rx_en = 0;
      end
    join
    chk(!v_o, "R7 aborted frame not delivered", int'(v_o), 0);
    rx_en = 1; repeat (bit_cyc()) @(negedge clk);
    chk(!v_o, "R7 no late delivery", int'(v_o), 0);

    // R9: transmitter sources and their enables
    tx_empty = 1; repeat (2) @(negedge clk);
    chk(!irq_o, "R9 empty ignored when disabled", int'(irq_o), 0);
    teie = 1; repeat (2) @(negedge clk);
    chk(irq_o, "R9 empty source", int'(irq_o), 1);
    teie = 0; tx_empty = 0; tx_idle = 1; tiie = 1; repeat (2) @(negedge clk);
    chk(irq_o, "R9 idle source", int'(irq_o), 1);
    tiie = 0; repeat (2) @(negedge clk);
    chk(!irq_o, "R9 idle gated off", int'(irq_o), 0);
    tx_idle = 0;

    // R10: wake pulse in power-down
    rx_en = 0; pdn = 1; wake_en = 1; @(negedge clk);
    begin
      int pulses = 0;
      rx = 0; fall_cyc = cyc;
      for (int i = 0; i < 8; i++) begin @(negedge clk); pulses += int'(wake_o); end
      chk(pulses == 1, "R10 single wake pulse", pulses, 1);
      rx = 1; repeat (4) @(negedge clk);
      wake_en = 0; pulses = 0;
      rx = 0; fall_cyc = cyc;
      for (int i = 0; i < 8; i++) begin @(negedge clk); pulses += int'(wake_o); end
      chk(pulses == 0, "R10 no wake when disabled", pulses, 0);
      rx = 1; repeat (4) @(negedge clk);
    end
    pdn = 0; rx_en = 1;

    // R8: global enable releases the pin
    uart_en = 0; @(negedge clk);
    chk(!own_o, "R8 pin released", int'(own_o), 0);
    uart_en = 1; @(negedge clk);
    chk(own_o, "R8 pin owned", int'(own_o), 1);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule